// File: doc/BRIEF.md
# Cached SRAM Front End with Write-Back Buffer

This block models the fast side of a cached memory device: a 1024-word by 16-bit SRAM cache, an 8-word staging buffer, and a block-wide port towards a slower backing array. Each rising clock edge samples a command that is formed from a read/write select and two control strobes. The command can be an SRAM access, a buffer access, a block transfer between buffer and SRAM or backing array, or a deselect.

Two per-byte lane enables choose which halves of the 16-bit word are written, and which halves drive the shared bidirectional data bus. An active-low output enable takes the whole bus to high impedance without waiting for a clock. Every buffer write records, byte by byte, which bytes are waiting to go out. A write transfer to the backing array carries only those bytes and then re-arms the mask.

A small mode register selects when read data reaches the bus. In transparent mode it appears in the same cycle. In latched mode it appears in the same cycle and is held afterwards. In registered mode it appears from the next edge on.

Top module: `cache_sram_front`

## Requirements
- R1: The SRAM holds 1024 words of 16 bits. Address bits 9..3 select one of 128 blocks and bits 2..0 select one of 8 words in a block. An SRAM read returns the last value written to that address.
- R2: Commands are decoded from ctlA, ctlB and rdWrN, where rdWrN=1 is read-type and rdWrN=0 is write-type. ctlA=1,ctlB=0 is an SRAM access. ctlA=0,ctlB=0 is a buffer access. ctlA=0,ctlB=1 is a transfer. ctlA=1,ctlB=1 is deselect.
- R3: A deselect cycle changes no SRAM, buffer, mask or hold state and starts no transfer, whatever the other inputs are.
- R4: laneEn[1] controls data bits 15..8 and laneEn[0] controls bits 7..0. An SRAM write or a buffer write updates only the enabled bytes.
- R5: While outEnN is 1, all 16 data lines are undriven. While outEnN is 0, a byte is driven only if its lane enable is 1.
- R6: The buffer holds 8 words, addressed by addr[2:0]. A buffer write clears mask bit (word*2 + lane) for every enabled lane. After reset, all 16 mask bits are set.
- R7: A write transfer (ctlA=0, ctlB=1, rdWrN=0) raises dramValid for exactly the following cycle. In that cycle dramBlock equals addr[9:3], word w of the buffer appears at dramData[16w+15:16w], and dramByteEn is the inverse of the mask. After the transfer, all mask bits are set again.
- R8: A read transfer (ctlA=0, ctlB=1, rdWrN=1) copies all 8 buffer words into the SRAM block selected by addr[9:3].
- R9: Pulsing modeLoad loads modeVal into the output mode register at the edge: 0 selects transparent, 1 selects latched, and 2 or 3 selects registered. The mode after reset is transparent.
- R10: In transparent mode, the bus shows the addressed word during a read cycle and zero in any other cycle.
- R11: In latched mode, the bus shows the addressed word during a read cycle. In other cycles it shows the word captured by the most recent read.
- R12: In registered mode, the bus shows the word captured at the most recent read edge. The captured word is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdWrN | input | 1 | 1 selects a read-type command, 0 selects a write-type command |
| ctlA | input | 1 | Control strobe A, low for buffer and transfer commands |
| ctlB | input | 1 | Control strobe B, high for transfers and deselect |
| addr | input | 10 | Word address: block in bits 9..3, word in bits 2..0 |
| laneEn | input | 2 | Per-byte enable, bit 1 for the upper byte and bit 0 for the lower byte |
| outEnN | input | 1 | Active-low asynchronous output enable |
| modeLoad | input | 1 | Loads modeVal into the output mode register |
| modeVal | input | 2 | Output timing mode to load |
| dataIo | inout | 16 | Bidirectional data bus |
| dramValid | output | 1 | One-cycle pulse carrying a block to the backing array |
| dramBlock | output | 7 | Block index of the transfer |
| dramData | output | 128 | Eight buffer words, word w at bits 16w+15..16w |
| dramByteEn | output | 16 | Per-byte write enable for the transfer |

## Verification
A mode register load can share a cycle with a read. The read word is then captured at the same edge where the new mode takes effect, so the bus value in the following cycles depends on both events at once. The random phase issues mode loads at random alongside every command type. A bench model captures the read word before it applies the mode change, and checks each later cycle under the new mode. A buffer write followed directly by a write transfer is also provoked, both in the directed cases and in the random mix. The bytes it cleared must appear in dramByteEn on the very next cycle, and the mask must then be armed again.

// File: rtl/csf_pkg.sv
package csf_pkg;

  typedef enum logic [1:0] {
    MODE_TRANSP = 2'd0,
    MODE_LATCH  = 2'd1,
    MODE_REG    = 2'd2
  } outMode_t;

  typedef struct packed {
    logic sramWr;
    logic bufWr;
    logic xferIn;
    logic xferOut;
    logic rdEn;
    logic rdBuf;
  } strobes_t;

endpackage

// File: rtl/csf_ctrl.sv
module csf_ctrl
  import csf_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rdWrN,
  input  logic     ctlA,
  input  logic     ctlB,
  input  logic     modeLoad,
  input  logic [1:0] modeVal,
  output strobes_t strb,
  output outMode_t modeQ
);

  // Command decode from the two strobes and the read/write select
  always_comb begin
    strb = '0;
    unique case ({ctlA, ctlB})
      2'b10: begin
        if (rdWrN) strb.rdEn   = 1'b1;
        else       strb.sramWr = 1'b1;
      end
      2'b00: begin
        if (rdWrN) begin
          strb.rdEn  = 1'b1;
          strb.rdBuf = 1'b1;
        end else begin
          strb.bufWr = 1'b1;
        end
      end
      2'b01: begin
        if (rdWrN) strb.xferIn  = 1'b1;
        else       strb.xferOut = 1'b1;
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_TRANSP;
    end else if (modeLoad) begin
      unique case (modeVal)
        2'd0:    modeQ <= MODE_TRANSP;
        2'd1:    modeQ <= MODE_LATCH;
        default: modeQ <= MODE_REG;
      endcase
    end
  end

endmodule

// File: rtl/csf_datapath.sv
module csf_datapath
  import csf_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int WORD_W    = 16,
  parameter int BLK_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobes_t                      strb,
  input  outMode_t                      modeQ,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [WORD_W/8-1:0]           laneEn,
  input  logic [WORD_W-1:0]             wrData,
  output logic [WORD_W-1:0]             rdOut,
  output logic                          dramValid,
  output logic [ADDR_W-$clog2(BLK_WORDS)-1:0] dramBlock,
  output logic [BLK_WORDS*WORD_W-1:0]   dramData,
  output logic [BLK_WORDS*WORD_W/8-1:0] dramByteEn
);

  localparam int OFF_W  = $clog2(BLK_WORDS);
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int LANES  = WORD_W / 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int MASK_W = BLK_WORDS * LANES;

  logic [WORD_W-1:0] sramMem [DEPTH];
  logic [WORD_W-1:0] bufMem  [BLK_WORDS];
  logic [MASK_W-1:0] maskQ;
  logic [WORD_W-1:0] holdQ;
  logic [WORD_W-1:0] rdWord;
  logic [BLK_W-1:0]  blkSel;
  logic [OFF_W-1:0]  offSel;

  assign blkSel = addr[ADDR_W-1:OFF_W];
  assign offSel = addr[OFF_W-1:0];
  assign rdWord = strb.rdBuf ? bufMem[offSel] : sramMem[addr];

  // SRAM array: byte writes and whole-block fill from the buffer
  always_ff @(posedge clk) begin
    if (rstN) begin
      for (int l = 0; l < LANES; l++) begin
        if (strb.sramWr && laneEn[l])
          sramMem[addr][l*8 +: 8] <= wrData[l*8 +: 8];
      end
      if (strb.xferIn) begin
        for (int w = 0; w < BLK_WORDS; w++)
          sramMem[{blkSel, OFF_W'(w)}] <= bufMem[w];
      end
    end
  end

  // Buffer, pending-byte mask and backing-array port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < BLK_WORDS; w++) bufMem[w] <= '0;
      maskQ      <= '1;
      dramValid  <= 1'b0;
      dramBlock  <= '0;
      dramData   <= '0;
      dramByteEn <= '0;
    end else begin
      dramValid <= strb.xferOut;
      if (strb.bufWr) begin
        for (int l = 0; l < LANES; l++) begin
          if (laneEn[l]) begin
            bufMem[offSel][l*8 +: 8]          <= wrData[l*8 +: 8];
            maskQ[int'(offSel) * LANES + l] <= 1'b0;
          end
        end
      end
      if (strb.xferOut) begin
        for (int w = 0; w < BLK_WORDS; w++)
          dramData[w*WORD_W +: WORD_W] <= bufMem[w];
        dramBlock  <= blkSel;
        dramByteEn <= ~maskQ;
        maskQ      <= '1;
      end
    end
  end

  // Read capture and output timing selection
  always_ff @(posedge clk) begin
    if (!rstN)          holdQ <= '0;
    else if (strb.rdEn) holdQ <= rdWord;
  end

  always_comb begin
    unique case (modeQ)
      MODE_TRANSP: rdOut = strb.rdEn ? rdWord : '0;
      MODE_LATCH:  rdOut = strb.rdEn ? rdWord : holdQ;
      default:     rdOut = holdQ;
    endcase
  end

endmodule

// File: rtl/cache_sram_front.sv
module cache_sram_front
  import csf_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int WORD_W    = 16,
  parameter int BLK_WORDS = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  rdWrN,
  input  logic                                  ctlA,
  input  logic                                  ctlB,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [WORD_W/8-1:0]                   laneEn,
  input  logic                                  outEnN,
  input  logic                                  modeLoad,
  input  logic [1:0]                            modeVal,
  inout  wire  [WORD_W-1:0]                     dataIo,
  output logic                                  dramValid,
  output logic [ADDR_W-$clog2(BLK_WORDS)-1:0]   dramBlock,
  output logic [BLK_WORDS*WORD_W-1:0]           dramData,
  output logic [BLK_WORDS*WORD_W/8-1:0]         dramByteEn
);

  localparam int LANES = WORD_W / 8;

  strobes_t          strb;
  outMode_t          modeQ;
  logic [WORD_W-1:0] rdOut;
  logic [WORD_W-1:0] wrData;
  logic [LANES-1:0]  driveLane;

  csf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdWrN    (rdWrN),
    .ctlA     (ctlA),
    .ctlB     (ctlB),
    .modeLoad (modeLoad),
    .modeVal  (modeVal),
    .strb     (strb),
    .modeQ    (modeQ)
  );

  csf_datapath #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .BLK_WORDS (BLK_WORDS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .modeQ      (modeQ),
    .addr       (addr),
    .laneEn     (laneEn),
    .wrData     (wrData),
    .rdOut      (rdOut),
    .dramValid  (dramValid),
    .dramBlock  (dramBlock),
    .dramData   (dramData),
    .dramByteEn (dramByteEn)
  );

  assign wrData = dataIo;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign driveLane[l]       = !outEnN && laneEn[l];
    assign dataIo[l*8 +: 8]   = driveLane[l] ? rdOut[l*8 +: 8] : 8'hzz;
  end

endmodule

// File: rtl/csf_checker.sv
module csf_checker
  import csf_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdWrN,
  input logic             ctlA,
  input logic             ctlB,
  input logic             outEnN,
  input logic             modeLoad,
  input logic [1:0]       modeVal,
  input logic             dramValid,
  input logic [LANES-1:0] driveLane,
  input strobes_t         strb,
  input outMode_t         modeQ
);

  a_r5_bus_released: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (driveLane == '0));

  a_r3_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ctlA && ctlB) |-> (strb == '0));

  a_r2_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.sramWr, strb.bufWr, strb.xferIn, strb.xferOut, strb.rdEn}));

  a_r7_xfer_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlA && ctlB && !rdWrN) |=> dramValid);

  a_r7_no_stray_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !(!ctlA && ctlB && !rdWrN) |=> !dramValid);

  a_r9_mode_load: assert property (@(posedge clk) disable iff (!rstN)
    modeLoad |=> (modeQ == (($past(modeVal) == 2'd0) ? MODE_TRANSP :
                            ($past(modeVal) == 2'd1) ? MODE_LATCH : MODE_REG)));

  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !modeLoad |=> $stable(modeQ));

endmodule

bind cache_sram_front csf_checker #(.LANES(WORD_W/8)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdWrN     (rdWrN),
  .ctlA      (ctlA),
  .ctlB      (ctlB),
  .outEnN    (outEnN),
  .modeLoad  (modeLoad),
  .modeVal   (modeVal),
  .dramValid (dramValid),
  .driveLane (driveLane),
  .strb      (strb),
  .modeQ     (modeQ)
);

// File: tb/cache_sram_front_bench.sv
`timescale 1ns/1ps
module cache_sram_front_bench;

  logic         clk = 1'b0;
  logic         rstN;
  logic         rdWrN, ctlA, ctlB, outEnN, modeLoad;
  logic [9:0]   addr;
  logic [1:0]   laneEn, modeVal;
  wire  [15:0]  dataIo;
  logic         dramValid;
  logic [6:0]   dramBlock;
  logic [127:0] dramData;
  logic [15:0]  dramByteEn;

  logic [15:0]  tbDrv;
  logic [1:0]   tbEn;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 0;

  // bench-side model
  logic [15:0]  mSram [1024];
  logic [15:0]  mBuf  [8];
  logic [15:0]  mMask;
  logic [15:0]  mHold;
  int           mMode;

  always #2 clk = ~clk;

  assign dataIo[7:0]  = tbEn[0] ? tbDrv[7:0]  : 8'hzz;
  assign dataIo[15:8] = tbEn[1] ? tbDrv[15:8] : 8'hzz;

  cache_sram_front u_cache_sram_front (
    .clk (clk), .rstN (rstN), .rdWrN (rdWrN), .ctlA (ctlA), .ctlB (ctlB),
    .addr (addr), .laneEn (laneEn), .outEnN (outEnN), .modeLoad (modeLoad),
    .modeVal (modeVal), .dataIo (dataIo), .dramValid (dramValid),
    .dramBlock (dramBlock), .dramData (dramData), .dramByteEn (dramByteEn)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string modeReq(input int m);
    if (m == 0) return "R10";
    if (m == 1) return "R11";
    return "R12";
  endfunction

  function automatic logic [15:0] expBus(input int m, input bit isRd,
                                         input logic [15:0] rw, input logic [15:0] hold);
    if (m == 0) return isRd ? rw : 16'h0;
    if (m == 1) return isRd ? rw : hold;
    return hold;
  endfunction

  // One command cycle: drive at negedge, check bus, clock, update model, check port
  task automatic cyc(input bit rw, input bit a, input bit b, input logic [9:0] ad,
                     input logic [1:0] ln, input bit oe, input bit ml,
                     input logic [1:0] mv, input logic [15:0] wd, input string tag);
    bit isRd, isBufRd, xOut;
    logic [15:0] rdw, expv;
    logic [127:0] expData;
    logic [15:0] expEn;
    @(negedge clk);
    rdWrN = rw; ctlA = a; ctlB = b; addr = ad; laneEn = ln; outEnN = oe;
    modeLoad = ml; modeVal = mv;
    isRd    = rw && !b;
    isBufRd = rw && !a && !b;
    rdw     = isBufRd ? mBuf[ad[2:0]] : mSram[ad];
    expv    = expBus(mMode, isRd, rdw, mHold);
    for (int l = 0; l < 2; l++) tbEn[l] = oe || !ln[l];
    tbDrv = wd;
    #1;
    for (int l = 0; l < 2; l++) begin
      if (tbEn[l]) chk({tag, " R5 released byte"}, 128'(dataIo[l*8 +: 8]), 128'(wd[l*8 +: 8]));
      else         chk({tag, " ", modeReq(mMode)}, 128'(dataIo[l*8 +: 8]), 128'(expv[l*8 +: 8]));
    end
    @(posedge clk);
    xOut = !rw && !a && b;
    expData = '0;
    for (int w = 0; w < 8; w++) expData[w*16 +: 16] = mBuf[w];
    expEn = ~mMask;
    if (!rw && a && !b) begin
      for (int l = 0; l < 2; l++) if (ln[l]) mSram[ad][l*8 +: 8] = wd[l*8 +: 8];
    end
    if (!rw && !a && !b) begin
      for (int l = 0; l < 2; l++) if (ln[l]) begin
        mBuf[ad[2:0]][l*8 +: 8] = wd[l*8 +: 8];
        mMask[ad[2:0]*2 + l] = 1'b0;
      end
    end
    if (rw && !a && b) begin
      for (int w = 0; w < 8; w++) mSram[{ad[9:3], 3'(w)}] = mBuf[w];
    end
    if (xOut) mMask = 16'hffff;
    if (isRd) mHold = rdw;
    if (ml) mMode = (mv == 2'd0) ? 0 : (mv == 2'd1) ? 1 : 2;
    #1;
    chk({tag, " R7 pulse"}, 128'(dramValid), 128'(xOut));
    if (xOut) begin
      chk({tag, " R7 data"},  dramData, expData);
      chk({tag, " R7 bytes"}, 128'(dramByteEn), 128'(expEn));
      chk({tag, " R7 block"}, 128'(dramBlock), 128'(ad[9:3]));
    end
  endtask

  // shorthand command helpers
  task automatic sramWr(input logic [9:0] ad, input logic [1:0] ln, input logic [15:0] wd, input string t);
    cyc(0, 1, 0, ad, ln, 1, 0, 0, wd, t);
  endtask
  task automatic sramRd(input logic [9:0] ad, input string t);
    cyc(1, 1, 0, ad, 2'b11, 0, 0, 0, 16'h0, t);
  endtask
  task automatic bufWr(input logic [2:0] w, input logic [1:0] ln, input logic [15:0] wd, input string t);
    cyc(0, 0, 0, {7'd0, w}, ln, 1, 0, 0, wd, t);
  endtask
  task automatic idle(input string t);
    cyc(1, 1, 1, 10'd0, 2'b11, 0, 0, 0, 16'h0, t);
  endtask
  task automatic setMode(input logic [1:0] mv, input string t);
    cyc(1, 1, 1, 10'd0, 2'b11, 0, 1, mv, 16'h0, t);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin : main
    int seedDummy;
    seedDummy = $urandom(32'h1C0DE5);
    rstN = 0; rdWrN = 1; ctlA = 1; ctlB = 1; addr = '0; laneEn = 2'b11;
    outEnN = 1; modeLoad = 0; modeVal = 0; tbDrv = '0; tbEn = 2'b11;
    for (int w = 0; w < 8; w++) mBuf[w] = '0;
    mMask = 16'hffff; mHold = '0; mMode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // reset state: no transfer pulse, transparent idle bus is zero
    idle("reset R9 R12");

    // fill every SRAM word (R1)
    for (int i = 0; i < 1024; i++) sramWr(10'(i), 2'b11, 16'($urandom), "R1 fill");
    for (int i = 0; i < 40; i++) sramRd(10'($urandom), "R1 readback");

    // R4: upper-lane-only write keeps the lower byte
    sramWr(10'h155, 2'b11, 16'hA1B2, "R4 base");
    sramWr(10'h155, 2'b10, 16'h7788, "R4 upper only");
    sramRd(10'h155, "R4 read");
    sramWr(10'h155, 2'b01, 16'h99CC, "R4 lower only");
    sramRd(10'h155, "R4 read2");
    // R5: one lane not driven during a read
    cyc(1, 1, 0, 10'h155, 2'b01, 0, 0, 0, 16'h3C3C, "R5 lane off");
    cyc(1, 1, 0, 10'h155, 2'b11, 1, 0, 0, 16'h5A5A, "R5 oe high");

    // R6 R7: a lower-byte buffer write at word 3 leaves only mask bit 6 cleared
    bufWr(3'd3, 2'b01, 16'hDEAD, "R6 buf write");
    cyc(1, 0, 0, 10'd3, 2'b11, 0, 0, 0, 16'h0, "R6 buf read");
    cyc(0, 0, 1, 10'h2A8, 2'b11, 1, 0, 0, 16'h0, "R7 first xfer");
    cyc(0, 0, 1, 10'h018, 2'b11, 1, 0, 0, 16'h0, "R7 rearmed");
    bufWr(3'd7, 2'b10, 16'hBEEF, "R6 back to back");
    cyc(0, 0, 1, 10'h3F8, 2'b11, 1, 0, 0, 16'h0, "R7 after write");

    // R8: buffer into SRAM block 5, then read the block back
    for (int w = 0; w < 8; w++) bufWr(3'(w), 2'b11, 16'h1000 + 16'(w), "R8 load");
    cyc(1, 0, 1, {7'd5, 3'd0}, 2'b11, 0, 0, 0, 16'h0, "R8 fill");
    for (int w = 0; w < 8; w++) sramRd({7'd5, 3'(w)}, "R8 readback");

    // R3: deselect with write-type select and data on the bus changes nothing
    cyc(0, 1, 1, 10'h155, 2'b11, 1, 0, 0, 16'hFFFF, "R3 deselect");
    sramRd(10'h155, "R3 read");

    // R11: latched mode holds the last read through idle cycles
    setMode(2'd1, "R9 latch");
    sramRd(10'h0A0, "R11 read");
    idle("R11 hold");
    idle("R11 hold2");
    // R12: registered mode shows the old word during the read cycle, the new one after
    setMode(2'd3, "R9 code3");
    sramRd(10'h155, "R12 read");
    idle("R12 after");
    // R10: transparent returns to zero when not reading
    setMode(2'd0, "R9 transp");
    idle("R10 idle");

    // constrained random mix, mode loads may coincide with reads (R2)
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit rw, a, b, oe, ml;
      logic [1:0] ln;
      r  = int'($urandom % 16);
      ln = 2'($urandom);
      ml = ($urandom % 12) == 0;
      oe = ($urandom % 5) == 0;
      case (r)
        0, 1, 2, 3, 4: begin rw = 1; a = 1; b = 0; end
        5, 6, 7:       begin rw = 0; a = 1; b = 0; end
        8, 9:          begin rw = 0; a = 0; b = 0; end
        10, 11:        begin rw = 1; a = 0; b = 0; end
        12:            begin rw = 1; a = 0; b = 1; end
        13:            begin rw = 0; a = 0; b = 1; end
        default:       begin rw = 1'($urandom); a = 1; b = 1; end
      endcase
      if (!rw) oe = 1;
      cyc(rw, a, b, 10'($urandom), ln, oe, ml, 2'($urandom), 16'($urandom), "R2 random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule